// File: doc/BRIEF.md
# Serial Receive Buffer with Single-Register Bypass

This block sits between a serial deserializer and the data register of a serial port. Each received character enters as an entry of eight data bits with a four-bit error field above them: framing at bit 8, parity at bit 9, break at bit 10 and overrun at bit 11. A mode bit written through the line-control path picks the storage shape. When the bit is set, entries queue in a power-of-two FIFO. When it is clear, the buffer behaves as one holding register. Any write that flips the mode bit discards whatever is stored.

A data-register read pops the oldest entry onto a registered read port. The same read copies that entry's error field into a separate receive-status register, which software clears with a write strobe. The block drives receive-full and receive-empty flags inside an eight-bit flag vector. It also raises a receive interrupt when the buffer stops being empty and drops it when the buffer drains. The trigger level is fixed at one entry.

Top module: `uart_rxbuf`

## Requirements
- R1: The effective depth is DEPTH while the mode bit is 1 and one entry while it is 0. A push is refused while the count equals the effective depth, and receive-full is set exactly when the count equals the effective depth.
- R2: The flag vector has receive-full at bit 6, receive-empty at bit 4, transmit-empty at bit 7 held at 1 and transmit-full at bit 5 held at 0. All other bits are 0. The value after reset is 0x90.
- R3: A line-control write whose mode bit differs from the current mode clears the count and read pointer and sets the flags to 0x90. A push or pop in that cycle does not change the count. A write that carries the current mode value has no effect. The interrupt is left unchanged by either kind of write.
- R4: A push stores its entry at slot (read pointer + count) modulo the effective depth, so entries are popped in push order.
- R5: A read strobe loads the entry at the read pointer into the read-data register, visible one cycle later. The pointer advances and the count falls only if the count was nonzero. A read while empty therefore returns the stale entry at the read pointer and leaves the flags as they were.
- R6: In a cycle with both a push and a read, both are judged on the count at the start of that cycle. When both are accepted the count is unchanged and both pointers move.
- R7: Every read strobe loads bits 11..8 of the returned entry into the status register. A clear strobe zeroes the status register. When a read and a clear fall in the same cycle, the read wins.
- R8: The break input pushes an entry with error bit 10 set and all other bits zero. It takes precedence over character data presented in the same cycle.
- R9: The receive interrupt is set when an accepted push without an accepted pop makes the count 1. It is cleared when an accepted pop without an accepted push makes the count 0. Otherwise it holds its value.
- R10: Synchronous reset selects single-register mode, empties the buffer, and zeroes the read data, the status register and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Deserializer presents a character |
| rx_char | input | DATA_W | Received character |
| rx_err | input | ERR_W | Error flags for the character (bit 2 = break) |
| rx_break | input | 1 | Break detected; pushes a break entry |
| dr_read | input | 1 | Data-register read strobe (pop) |
| lcr_write | input | 1 | Line-control write strobe |
| lcr_fifo_en | input | 1 | Mode bit carried by the line-control write |
| rsr_clear | input | 1 | Status-register write strobe (clears it) |
| dr_rdata | output | DATA_W+ERR_W | Entry returned by the last read |
| rsr_q | output | ERR_W | Receive-status register |
| flags | output | 8 | Flag vector |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench goes after the depth boundary and the pointer wrap in both modes. A wrong refusal rule would overwrite the oldest entry, and a wrong mask would make bypass mode hold more than one entry. It reads while empty to prove the entry comes back stale and the pointer stays put; an unguarded decrement would wrap the count and show a full buffer. It toggles the mode with data inside and also rewrites the same mode, because a design keyed to the write instead of the change would silently drop stored characters. It also collides a push with a read, a read with a status clear, and a break with character data; getting any of these wrong corrupts the count, the status register or the break encoding.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  // receive interrupt trigger level (entries)
  localparam int RX_TRIG   = 1;
  // index of the break flag inside the error field
  localparam int ERR_BRK   = 2;
  // flag vector bit positions
  localparam int FLG_RXE   = 4;
  localparam int FLG_TXF   = 5;
  localparam int FLG_RXF   = 6;
  localparam int FLG_TXE   = 7;
endpackage

// File: rtl/uart_rxbuf_store.sv
module uart_rxbuf_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_idx,
  output logic [ENT_W-1:0] rd_q
);
  logic [ENT_W-1:0] mem [DEPTH];

  // write port, no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // read-first synchronous read with resettable output register
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_idx];
  end
endmodule

// File: rtl/uart_rxbuf_ctrl.sv
module uart_rxbuf_ctrl
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          lcr_wr,
  input  logic          lcr_fen,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic          full_q,
  output logic          empty_q,
  output logic          irq_q
);
  logic          fen_q;
  logic [AW-1:0] rptr_q, rptr_nx, mask;
  logic [CW-1:0] cnt_q, cnt_nx, eff_depth;
  logic          mode_chg, do_push, do_pop, irq_set, irq_clr;

  always_comb begin
    eff_depth = fen_q ? CW'(DEPTH) : CW'(1);
    mask      = fen_q ? AW'(DEPTH - 1) : '0;
    mode_chg  = lcr_wr && (lcr_fen != fen_q);
    do_push   = push_req && (cnt_q != eff_depth) && !mode_chg;
    do_pop    = pop_req && (cnt_q != '0) && !mode_chg;
    cnt_nx    = cnt_q + CW'(do_push) - CW'(do_pop);
    rptr_nx   = do_pop ? ((rptr_q + AW'(1)) & mask) : rptr_q;
    wr_idx    = (rptr_q + cnt_q[AW-1:0]) & mask;
    irq_set   = do_push && !do_pop && (cnt_nx == CW'(RX_TRIG));
    irq_clr   = do_pop && !do_push && (cnt_nx == CW'(RX_TRIG - 1));
  end

  assign wr_en  = do_push;
  assign rd_idx = rptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q   <= 1'b0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (mode_chg) begin
      fen_q   <= lcr_fen;
      rptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nx;
      rptr_q  <= rptr_nx;
      full_q  <= (cnt_nx == eff_depth);
      empty_q <= (cnt_nx == '0);
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxbuf_status.sv
module uart_rxbuf_status #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [ERR_W-1:0] cap_val,
  input  logic             clr,
  output logic [ERR_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst)         status_q <= '0;
    else if (cap_en) status_q <= cap_val;
    else if (clr)    status_q <= '0;
  end
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  localparam int ENT_W = DATA_W + ERR_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_char,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rx_break,
  input  logic              dr_read,
  input  logic              lcr_write,
  input  logic              lcr_fifo_en,
  input  logic              rsr_clear,
  output logic [ENT_W-1:0]  dr_rdata,
  output logic [ERR_W-1:0]  rsr_q,
  output logic [7:0]        flags,
  output logic              rx_irq
);
  logic             push_req, wr_en, full_q, empty_q;
  logic [AW-1:0]    wr_idx, rd_idx;
  logic [ENT_W-1:0] push_ent;
  logic [ERR_W-1:0] brk_err;

  // break entry: only the break flag set, data forced to zero
  always_comb begin
    brk_err          = '0;
    brk_err[ERR_BRK] = 1'b1;
  end

  assign push_req = rx_push | rx_break;
  assign push_ent = rx_break ? {brk_err, {DATA_W{1'b0}}} : {rx_err, rx_char};

  uart_rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(push_req), .pop_req(dr_read),
    .lcr_wr(lcr_write), .lcr_fen(lcr_fifo_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .full_q(full_q), .empty_q(empty_q), .irq_q(rx_irq)
  );

  uart_rxbuf_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(push_ent),
    .rd_en(dr_read), .rd_idx(rd_idx), .rd_q(dr_rdata)
  );

  // status loads from the same entry the read register captures
  uart_rxbuf_status #(.ERR_W(ERR_W)) u_status (
    .clk(clk), .rst(rst),
    .cap_en(dr_read), .cap_val(push_sel_err(rd_idx)),
    .clr(rsr_clear), .status_q(rsr_q)
  );

  function automatic logic [ERR_W-1:0] push_sel_err(input logic [AW-1:0] idx);
    return u_store.mem[idx][ENT_W-1:DATA_W];
  endfunction

  always_comb begin
    flags          = 8'h00;
    flags[FLG_TXE] = 1'b1;
    flags[FLG_TXF] = 1'b0;
    flags[FLG_RXF] = full_q;
    flags[FLG_RXE] = empty_q;
  end
endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk
  import uart_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  localparam int ENT_W = DATA_W + ERR_W
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_push,
  input logic             rx_break,
  input logic             dr_read,
  input logic             lcr_write,
  input logic             lcr_fifo_en,
  input logic             rsr_clear,
  input logic [ENT_W-1:0] dr_rdata,
  input logic [ERR_W-1:0] rsr_q,
  input logic [7:0]       flags,
  input logic             rx_irq
);
  logic fen_sh;
  always_ff @(posedge clk) begin
    if (rst)            fen_sh <= 1'b0;
    else if (lcr_write) fen_sh <= lcr_fifo_en;
  end

  logic pushing;
  assign pushing = rx_push | rx_break;

  // R2
  no_full_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(flags[FLG_RXF] && flags[FLG_RXE]));
  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FLG_RXF] && pushing && !dr_read && !lcr_write) |=> flags[FLG_RXF]);
  // R1
  bypass_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!fen_sh && flags[FLG_RXE] && pushing && !lcr_write) |=> flags[FLG_RXF]);
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FLG_RXE] && dr_read && !pushing && !lcr_write) |=> flags[FLG_RXE]);
  // R3
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (lcr_write && (lcr_fifo_en != fen_sh)) |=> (flags == 8'h90));
  // R7
  status_cap_chk: assert property (@(posedge clk) disable iff (rst)
    dr_read |=> (rsr_q == dr_rdata[ENT_W-1:DATA_W]));
  // R7
  status_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsr_clear && !dr_read) |=> (rsr_q == '0));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> (!flags[FLG_RXE] && $past(flags[FLG_RXE])));
endmodule

bind uart_rxbuf uart_rxbuf_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_push(rx_push), .rx_break(rx_break),
  .dr_read(dr_read), .lcr_write(lcr_write), .lcr_fifo_en(lcr_fifo_en),
  .rsr_clear(rsr_clear), .dr_rdata(dr_rdata), .rsr_q(rsr_q),
  .flags(flags), .rx_irq(rx_irq)
);

// File: tb/test_uart_rxbuf.sv
`timescale 1ns/1ps
module test_uart_rxbuf;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_push, rx_break, dr_read, lcr_write, lcr_fifo_en, rsr_clear;
  logic [7:0]  rx_char;
  logic [3:0]  rx_err;
  logic [11:0] dr_rdata;
  logic [3:0]  rsr_q;
  logic [7:0]  flags;
  logic        rx_irq;

  always #5 clk = ~clk;

  uart_rxbuf #(.DEPTH(D)) i_uart_rxbuf (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_char(rx_char), .rx_err(rx_err),
    .rx_break(rx_break), .dr_read(dr_read), .lcr_write(lcr_write),
    .lcr_fifo_en(lcr_fifo_en), .rsr_clear(rsr_clear), .dr_rdata(dr_rdata),
    .rsr_q(rsr_q), .flags(flags), .rx_irq(rx_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state computed from the requirements
  logic [11:0] m_mem [D];
  int          m_rptr, m_cnt;
  logic        m_fen, m_irq;
  logic [11:0] m_rd;
  logic [3:0]  m_st;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int eff = m_fen ? D : 1;
    int ef  = 8'h80 | ((m_cnt == eff) ? 8'h40 : 0) | ((m_cnt == 0) ? 8'h10 : 0);
    chk(tag, "flags", int'(flags), ef);
    chk(tag, "irq", int'(rx_irq), int'(m_irq));
    chk(tag, "status", int'(rsr_q), int'(m_st));
    chk(tag, "rdata", int'(dr_rdata), int'(m_rd));
  endtask

  task automatic step(input logic pv, input logic [7:0] d, input logic [3:0] e,
                      input logic brk, input logic pop, input logic lw,
                      input logic lf, input logic sc, input string tag);
    logic mchg, dpush, dpop;
    int eff;
    logic [11:0] ent;
    rx_push = pv; rx_char = d; rx_err = e; rx_break = brk; dr_read = pop;
    lcr_write = lw; lcr_fifo_en = lf; rsr_clear = sc;
    @(posedge clk); #1;
    eff   = m_fen ? D : 1;
    mchg  = lw && (lf != m_fen);
    ent   = brk ? 12'h400 : {e, d};
    dpush = (pv || brk) && (m_cnt != eff) && !mchg;
    dpop  = pop && (m_cnt != 0) && !mchg;
    if (pop) begin m_rd = m_mem[m_rptr]; m_st = m_rd[11:8]; end
    else if (sc) m_st = 4'h0;
    if (dpush) m_mem[(m_rptr + m_cnt) % eff] = ent;
    if (mchg) begin
      m_cnt = 0; m_rptr = 0; m_fen = lf;
    end else begin
      m_cnt = m_cnt + int'(dpush) - int'(dpop);
      if (dpop) m_rptr = (m_rptr + 1) % eff;
      if (dpush && !dpop && m_cnt == 1) m_irq = 1'b1;
      else if (dpop && !dpush && m_cnt == 0) m_irq = 1'b0;
    end
    rx_push = 0; rx_break = 0; dr_read = 0; lcr_write = 0; rsr_clear = 0;
    check_all(tag);
  endtask

  task automatic push(input logic [7:0] d, input logic [3:0] e, input string tag);
    step(1, d, e, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic pop(input string tag);
    step(0, 0, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic setmode(input logic f, input string tag);
    step(0, 0, 0, 0, 0, 1, f, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rx_push = 0; rx_char = 0; rx_err = 0; rx_break = 0; dr_read = 0;
    lcr_write = 0; lcr_fifo_en = 0; rsr_clear = 0;
    for (int i = 0; i < D; i++) m_mem[i] = '0;
    m_rptr = 0; m_cnt = 0; m_fen = 0; m_irq = 0; m_rd = 0; m_st = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10 / R2 reset state
    check_all("R10");
    chk("R2", "flags reset", int'(flags), 8'h90);

    // R3 enter FIFO mode, R4 fill in order, R1 refuse beyond depth
    setmode(1, "R3");
    for (int i = 0; i < D; i++) push(8'h10 + 8'(i), 4'(i), "R4");
    chk("R1", "full at depth", int'(flags[6]), 1);
    push(8'hEE, 4'h0, "R1");
    for (int i = 0; i < D; i++) begin
      pop("R5");
      chk("R4", "order", int'(dr_rdata[7:0]), 8'h10 + i);
    end
    // R5 read while empty: stale entry, pointer unmoved
    pop("R5");
    pop("R5");
    // R9 irq set on first push, cleared on drain
    push(8'h55, 4'h1, "R9");
    chk("R9", "irq set", int'(rx_irq), 1);
    // R6 push and pop together keep the count
    step(1, 8'h66, 4'h0, 0, 1, 0, 0, 0, "R6");
    step(1, 8'h67, 4'h2, 0, 1, 0, 0, 0, "R6");
    pop("R6");
    chk("R9", "irq clear", int'(rx_irq), 0);
    // R6 push and read on an empty buffer: push lands, read is stale
    step(1, 8'h70, 4'h0, 0, 1, 0, 0, 0, "R6");
    // R8 break wins over character data
    step(1, 8'hFF, 4'hF, 1, 0, 0, 0, 0, "R8");
    pop("R8");
    pop("R8");
    chk("R8", "break entry", int'(dr_rdata), 12'h400);
    chk("R8", "break status", int'(rsr_q), 4'h4);
    // R7 clear, and read beating clear
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
    push(8'h81, 4'h9, "R7");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R7");
    chk("R7", "read wins", int'(rsr_q), 4'h9);
    // R3 same value write keeps data, change flushes it
    push(8'h90, 4'h0, "R3");
    push(8'h91, 4'h0, "R3");
    setmode(1, "R3");
    chk("R3", "same write keeps", int'(flags[4]), 0);
    step(1, 8'h92, 4'h0, 0, 1, 1, 0, 0, "R3");
    chk("R3", "flush", int'(flags), 8'h90);
    // R1 bypass mode: single entry
    push(8'hA1, 4'h0, "R1");
    push(8'hA2, 4'h0, "R1");
    pop("R1");
    chk("R1", "bypass keeps first", int'(dr_rdata[7:0]), 8'hA1);
    pop("R1");

    // R4 pseudo-random sweep over all operations and both modes
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[15:8], lf[7:4], (lf[3:0] == 4'h9), lf[1],
           (lf[6:2] == 5'h11), lf[11], (lf[4:2] == 3'h5), "R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule